// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns one 64-bit virtual address into a physical byte address for a single access request. A request carries the address, the access it needs (read, write, execute, or none) and a two-bit privilege mode, where mode 0 is kernel. The walker first screens the address. An address that is not canonical fails at once. An address in the kernel-only direct-mapped segment is relocated with no memory traffic. Any other address is resolved by reading one entry from each of three page-table levels through a 64-bit read port.

The walker accepts a request only when idle, and it works on one request at a time. On the memory side the request channel is valid/ready. Once `mem_req_valid` is raised, it and `mem_req_addr` hold until `mem_req_ready` is seen high at a clock edge. The response channel is also valid/ready: `mem_rsp_ready` is high only while one read is outstanding, and a response is taken on the edge where `mem_rsp_valid` and `mem_rsp_ready` are both high. Completion is a one-cycle `done` pulse carrying the fault code, the granted permissions and the physical address.

Top module: `pgw_top`

## Requirements
- R1: An address whose bits 63:43 are not all equal completes with fault code 1 (access violation), makes no memory read, and raises `done` one cycle after acceptance.
- R2: An address with bit 63 set and bits 42:41 equal to 2'b10 is in the direct segment. In any mode other than 0 it completes with fault code 1, makes no read, and raises `done` one cycle after acceptance.
- R3: A direct-segment address in mode 0 completes with fault code 0 and permissions 3'b111. The physical address is built as follows: bits 39:0 are the address bits 39:0, bit 43 is address bit 40, and every other bit is 0. There is no read, and `done` comes one cycle after acceptance.
- R4: Any other address reads three entries, in order. The first is at `ptbr` + 8·addr[42:33]. The second is at (entry1[63:32] << 13) + 8·addr[32:23]. The third is at (entry2[63:32] << 13) + 8·addr[22:13].
- R5: A level-1 or level-2 entry whose bit 0 (valid) is clear completes with fault code 2. If bit 0 is set but bit 8 (kernel read enable) is clear, it completes with fault code 1. In both cases no further level is read.
- R6: A level-3 entry with bit 0 clear completes with fault code 2.
- R7: At level 3, read and execute rights come from entry bit 8+mode, and write rights come from entry bit 12+mode. Permissions are encoded as bit 0 read, bit 1 write, bit 2 execute. A required access (zero or one-hot in the same encoding) that is nonzero and not granted gives fault code 1.
- R8: Entry bits 1, 2 and 3 remove the granted read, write and execute rights respectively. If the required access is then lost, the fault code depends on the access: execute gives 5, write gives 4, read gives 3. Otherwise the result is code 0, the remaining rights, and the address (entry3[63:32] << 13) | addr[12:0].
- R9: `done` is high for exactly one cycle per request. When the fault code is nonzero, `done_perm` and `done_paddr` are zero. Fault codes never exceed 5.
- R10: `req_ready` is high only when no read is in flight. `mem_req_valid` and `mem_req_addr` hold until accepted. A new read is never requested while a response is awaited. `done` follows the accepted level-3 or faulting response by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptbr | input | 64 | Base address of the level-1 table, sampled at acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle; request accepted on valid and ready |
| req_vaddr | input | 64 | Virtual address |
| req_access | input | 3 | Required access: bit 0 read, bit 1 write, bit 2 execute, or zero |
| req_mode | input | 2 | Privilege mode, 0 is kernel |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Walker awaits read data |
| mem_rsp_data | input | 64 | Table entry read |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 3 | 0 ok, 1 access violation, 2 not valid, 3 read, 4 write, 5 execute fault-on |
| done_perm | output | 3 | Granted rights, same encoding as `req_access` |
| done_paddr | output | 64 | Physical byte address |

## Verification
Screened outcomes (non-canonical and direct segment) are due exactly one cycle after the accepting edge. The bench records the cycle count at the falling edge where it presents the request and expects `done` at the next falling edge. Walk outcomes are due one cycle after the edge that takes the last needed response. The bench's memory model notes the cycle in which it presents each response, and the bench requires `done` exactly one cycle later, then requires it low at the following falling edge. The memory model applies irregular back-pressure and variable response delay, so these latency checks hold across different handshake timings.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_ACV  = 3'd1,
    FLT_TNV  = 3'd2,
    FLT_FOR  = 3'd3,
    FLT_FOW  = 3'd4,
    FLT_FOE  = 3'd5
  } fault_e;

  // entry layout
  localparam int PTE_VALID   = 0;
  localparam int PTE_FO_LO   = 1;
  localparam int PTE_RE_BASE = 8;
  localparam int PTE_WE_BASE = 12;
  localparam int FRAME_LO    = 32;

  // permission encoding
  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;

  // direct segment selection and relocation
  localparam int DSEG_SEL_LO  = 41;
  localparam int DSEG_KEEP    = 40;
  localparam int DSEG_MOVE_TO = 43;
endpackage

// File: rtl/pgw_screen.sv
module pgw_screen
  import pgw_pkg::*;
#(
  parameter int VA_BITS = 43,
  parameter int MODE_W  = 2
) (
  input  logic [63:0]       vaddr,
  input  logic [MODE_W-1:0] mode,
  output logic              hit,
  output fault_e            fault,
  output logic [63:0]       paddr,
  output logic [2:0]        perm
);
  localparam int HI_W = 64 - VA_BITS;

  logic [HI_W-1:0] upper;
  logic canon, dseg;

  assign upper = vaddr[63:VA_BITS];
  assign canon = (upper == '0) || (upper == '1);
  assign dseg  = vaddr[63] && (vaddr[DSEG_SEL_LO+1:DSEG_SEL_LO] == 2'b10);

  always_comb begin
    hit   = 1'b0;
    fault = FLT_NONE;
    paddr = '0;
    perm  = '0;
    if (!canon) begin
      hit   = 1'b1;
      fault = FLT_ACV;
    end else if (dseg) begin
      hit = 1'b1;
      if (mode != '0) begin
        fault = FLT_ACV;
      end else begin
        perm = 3'b111;
        paddr[DSEG_KEEP-1:0] = vaddr[DSEG_KEEP-1:0];
        paddr[DSEG_MOVE_TO]  = vaddr[DSEG_KEEP];
      end
    end
  end
endmodule

// File: rtl/pgw_leaf.sv
module pgw_leaf
  import pgw_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic [15:0]       pte_lo,
  input  logic [2:0]        need,
  input  logic [MODE_W-1:0] mode,
  output fault_e            fault,
  output logic [2:0]        perm
);
  logic       rd, wr;
  logic [2:0] grant, masked;

  assign rd = pte_lo[PTE_RE_BASE + 32'(mode)];
  assign wr = pte_lo[PTE_WE_BASE + 32'(mode)];

  always_comb begin
    grant         = '0;
    grant[PERM_R] = rd;
    grant[PERM_X] = rd;
    grant[PERM_W] = wr;
    masked        = grant & ~pte_lo[PTE_FO_LO+2:PTE_FO_LO];
    fault         = FLT_NONE;
    perm          = '0;
    if (!pte_lo[PTE_VALID]) begin
      fault = FLT_TNV;
    end else if ((need != '0) && ((grant & need) == '0)) begin
      fault = FLT_ACV;
    end else if ((need != '0) && ((masked & need) == '0)) begin
      if (need[PERM_X])      fault = FLT_FOE;
      else if (need[PERM_W]) fault = FLT_FOW;
      else                   fault = FLT_FOR;
    end else begin
      perm = masked;
    end
  end
endmodule

// File: rtl/pgw_top.sv
module pgw_top
  import pgw_pkg::*;
#(
  parameter int VA_BITS  = 43,
  parameter int PG_BITS  = 13,
  parameter int IDX_BITS = 10,
  parameter int LEVELS   = 3,
  parameter int MODES    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [63:0]                ptbr,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [63:0]                req_vaddr,
  input  logic [2:0]                 req_access,
  input  logic [$clog2(MODES)-1:0]   req_mode,
  output logic                       mem_req_valid,
  input  logic                       mem_req_ready,
  output logic [63:0]                mem_req_addr,
  input  logic                       mem_rsp_valid,
  output logic                       mem_rsp_ready,
  input  logic [63:0]                mem_rsp_data,
  output logic                       done,
  output logic [2:0]                 done_fault,
  output logic [2:0]                 done_perm,
  output logic [63:0]                done_paddr
);
  localparam int MODE_W   = $clog2(MODES);
  localparam int LVL_W    = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int ENTRY_SH = 3;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_e;

  state_e              state;
  logic [VA_BITS-1:0]  va_q;
  logic [2:0]          need_q;
  logic [MODE_W-1:0]   mode_q;
  logic [63:0]         base_q;
  logic [LVL_W-1:0]    lvl_q;
  fault_e              res_fault;
  logic [2:0]          res_perm;
  logic [63:0]         res_paddr;

  logic                scr_hit;
  fault_e              scr_fault;
  logic [63:0]         scr_paddr;
  logic [2:0]          scr_perm;
  fault_e              leaf_fault;
  logic [2:0]          leaf_perm;
  logic [63:0]         next_base, page_off;
  logic                last_lvl;
  logic [IDX_BITS-1:0] lvl_idx [LEVELS];
  logic                unused_pte_bits;

  pgw_screen #(.VA_BITS(VA_BITS), .MODE_W(MODE_W)) u_screen (
    .vaddr(req_vaddr), .mode(req_mode),
    .hit(scr_hit), .fault(scr_fault), .paddr(scr_paddr), .perm(scr_perm)
  );

  pgw_leaf #(.MODE_W(MODE_W)) u_leaf (
    .pte_lo(mem_rsp_data[15:0]), .need(need_q), .mode(mode_q),
    .fault(leaf_fault), .perm(leaf_perm)
  );

  // per-level index fields, level 0 takes the highest slice
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign lvl_idx[g] = va_q[PG_BITS + IDX_BITS*(LEVELS-1-g) +: IDX_BITS];
  end

  assign unused_pte_bits = ^mem_rsp_data[FRAME_LO-1:16];
  assign next_base = {32'b0, mem_rsp_data[63:FRAME_LO]} << PG_BITS;
  assign page_off  = {{(64-PG_BITS){1'b0}}, va_q[PG_BITS-1:0]};
  assign last_lvl  = (lvl_q == LVL_W'(LEVELS-1));

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_ISSUE);
  assign mem_rsp_ready = (state == S_WAIT);
  assign mem_req_addr  = base_q + ({{(64-IDX_BITS){1'b0}}, lvl_idx[lvl_q]} << ENTRY_SH);
  assign done          = (state == S_DONE);
  assign done_fault    = res_fault;
  assign done_perm     = res_perm;
  assign done_paddr    = res_paddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      va_q      <= '0;
      need_q    <= '0;
      mode_q    <= '0;
      base_q    <= '0;
      lvl_q     <= '0;
      res_fault <= FLT_NONE;
      res_perm  <= '0;
      res_paddr <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q      <= req_vaddr[VA_BITS-1:0];
          need_q    <= req_access;
          mode_q    <= req_mode;
          base_q    <= ptbr;
          lvl_q     <= '0;
          res_fault <= scr_fault;
          res_perm  <= scr_perm;
          res_paddr <= scr_paddr;
          state     <= scr_hit ? S_DONE : S_ISSUE;
        end
        S_ISSUE: if (mem_req_ready) state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (last_lvl) begin
            res_fault <= leaf_fault;
            res_perm  <= leaf_perm;
            res_paddr <= (leaf_fault == FLT_NONE) ? (next_base | page_off) : '0;
            state     <= S_DONE;
          end else if (!mem_rsp_data[PTE_VALID]) begin
            res_fault <= FLT_TNV;
            res_perm  <= '0;
            res_paddr <= '0;
            state     <= S_DONE;
          end else if (!mem_rsp_data[PTE_RE_BASE]) begin
            res_fault <= FLT_ACV;
            res_perm  <= '0;
            res_paddr <= '0;
            state     <= S_DONE;
          end else begin
            base_q <= next_base;
            lvl_q  <= lvl_q + LVL_W'(1);
            state  <= S_ISSUE;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [63:0] req_vaddr,
  input logic [1:0]  req_mode,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [63:0] mem_req_addr,
  input logic        mem_rsp_ready,
  input logic        done,
  input logic [2:0]  done_fault,
  input logic [2:0]  done_perm,
  input logic [63:0] done_paddr
);
  logic accept, noncanon, dseg;
  assign accept   = req_valid && req_ready;
  assign noncanon = !((req_vaddr[63:43] == 21'h0) || (req_vaddr[63:43] == 21'h1FFFFF));
  assign dseg     = !noncanon && req_vaddr[63] && !req_vaddr[41] && req_vaddr[42];

  assert_noncanon_acv_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && noncanon |=> done && done_fault == 3'd1);
  assert_dseg_user_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && dseg && req_mode != 2'd0 |=> done && done_fault == 3'd1);
  assert_dseg_kernel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && dseg && req_mode == 2'd0 |=> done && done_fault == 3'd0 && done_perm == 3'b111);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_fault_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_fault != 3'd0 |-> done_perm == 3'd0 && done_paddr == 64'd0);
  assert_code_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> done_fault <= 3'd5);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  assert_single_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> !mem_req_valid);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid && !mem_rsp_ready && !done);
endmodule

bind pgw_top pgw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .req_mode(req_mode), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .mem_rsp_ready(mem_rsp_ready), .done(done), .done_fault(done_fault),
  .done_perm(done_perm), .done_paddr(done_paddr)
);

// File: tb/tb_pgw_top.sv
`timescale 1ns/1ps
module tb_pgw_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] ptbr = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [2:0]  req_access = '0;
  logic [1:0]  req_mode = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [63:0] mem_rsp_data = '0;
  logic        done;
  logic [2:0]  done_fault, done_perm;
  logic [63:0] done_paddr;

  int checks = 0, errors = 0;
  int cyc = 0, reads = 0, last_rsp_cyc = 0;
  logic [63:0] t_va, t_l1, t_l2, t_l3;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pgw_top dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] lookup(input logic [63:0] a);
    logic [63:0] e1, e2, e3;
    e1 = ptbr + (64'(t_va[42:33]) << 3);
    e2 = (64'(t_l1[63:32]) << 13) + (64'(t_va[32:23]) << 3);
    e3 = (64'(t_l2[63:32]) << 13) + (64'(t_va[22:13]) << 3);
    if (a == e1) return t_l1;
    if (a == e2) return t_l2;
    if (a == e3) return t_l3;
    return 64'h0;
  endfunction

  // expected outcome from the requirements
  task automatic model(input logic [63:0] va, input logic [2:0] acc, input logic [1:0] md,
                       output logic [2:0] f, output logic [2:0] p,
                       output logic [63:0] pa, output int nr);
    logic rd, wr;
    logic [2:0] g, m;
    f = 3'd0; p = 3'd0; pa = 64'd0; nr = 0;
    if (va[63:43] != {21{va[63]}}) begin f = 3'd1; return; end
    if (va[63] && va[42:41] == 2'b10) begin
      if (md != 2'd0) f = 3'd1;
      else begin p = 3'b111; pa = {20'd0, va[40], 3'd0, va[39:0]}; end
      return;
    end
    nr = 1;
    if (!t_l1[0]) begin f = 3'd2; return; end
    if (!t_l1[8]) begin f = 3'd1; return; end
    nr = 2;
    if (!t_l2[0]) begin f = 3'd2; return; end
    if (!t_l2[8]) begin f = 3'd1; return; end
    nr = 3;
    if (!t_l3[0]) begin f = 3'd2; return; end
    rd = t_l3[8 + 32'(md)];
    wr = t_l3[12 + 32'(md)];
    g = {rd, wr, rd};
    if (acc != 3'd0 && (g & acc) == 3'd0) begin f = 3'd1; return; end
    m = g & ~t_l3[3:1];
    if (acc != 3'd0 && (m & acc) == 3'd0) begin
      f = acc[2] ? 3'd5 : (acc[1] ? 3'd4 : 3'd3);
      return;
    end
    p = m;
    pa = (64'(t_l3[63:32]) << 13) | 64'(va[12:0]);
  endtask

  // memory model: irregular ready, variable response delay
  initial begin
    logic [63:0] data;
    forever begin
      @(negedge clk);
      mem_req_ready = (cyc % 3) != 1;
      if (mem_req_valid && mem_req_ready) begin
        reads++;
        data = lookup(mem_req_addr);
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (cyc % 2 == 0) @(negedge clk);
        while (!mem_rsp_ready) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = data;
        last_rsp_cyc  = cyc;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
      end
    end
  end

  task automatic walk(input logic [63:0] va, input logic [2:0] acc, input logic [1:0] md,
                      input string req);
    logic [2:0] ef, ep;
    logic [63:0] ea;
    int er, acc_cyc, n;
    t_va = va;
    model(va, acc, md, ef, ep, ea, er);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    reads = 0;
    req_valid = 1'b1; req_vaddr = va; req_access = acc; req_mode = md;
    acc_cyc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    if (er == 0)
      chk(cyc == acc_cyc + 1, req, "screen latency", 64'(cyc - acc_cyc), 64'd1);
    else
      chk(cyc == last_rsp_cyc + 1, "R10", "walk latency", 64'(cyc - last_rsp_cyc), 64'd1);
    chk(done_fault == ef, req, "fault", 64'(done_fault), 64'(ef));
    chk(done_perm == ep, req, "perm", 64'(done_perm), 64'(ep));
    chk(done_paddr == ea, req, "paddr", done_paddr, ea);
    chk(reads == er, (er == 3) ? "R4" : req, "read count", 64'(reads), 64'(er));
    @(negedge clk);
    chk(!done, "R9", "done pulse width", 64'(done), 64'd0);
  endtask

  function automatic logic [63:0] sx43(input logic [42:0] v);
    return {{21{v[42]}}, v};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] va;
    logic [2:0]  acc;
    logic [3:0]  rb, wb;
    int k;
    ptbr = 64'h0010_0000;
    t_l1 = (64'h200 << 32) | 64'h101;
    t_l2 = (64'h300 << 32) | 64'h101;
    t_l3 = (64'h4567 << 32) | 64'h1F01;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!done && req_ready && !mem_req_valid && !mem_rsp_ready, "R9", "reset outputs",
        {60'd0, done, req_ready, mem_req_valid, mem_rsp_ready}, 64'h4);
    rst_n = 1'b1;

    // R1: flip each upper bit of a canonical address
    for (int b = 43; b < 64; b++) begin
      va = 64'h0000_0123_4567_8ABC;
      va[b] = ~va[b];
      walk(va, 3'd1, 2'(b % 4), "R1");
    end
    // bit 42 alone stays canonical and walks
    walk(64'h0000_0400_0000_0000, 3'd1, 2'd0, "R4");

    // R2 / R3: direct segment in every mode, with and without bit 40
    for (int md = 0; md < 4; md++) begin
      walk(64'hFFFF_FC00_0000_1234, 3'd2, 2'(md), md == 0 ? "R3" : "R2");
      walk(64'hFFFF_FD23_4567_89AB, 3'd4, 2'(md), md == 0 ? "R3" : "R2");
    end
    // negative with bits 42:41 = 11 is not the segment
    walk(64'hFFFF_FE00_1234_5678, 3'd1, 2'd0, "R4");

    // R5: intermediate-level faults
    t_l1 = (64'h200 << 32) | 64'h100;  walk(sx43(43'h123_4567_8000), 3'd1, 2'd0, "R5");
    t_l1 = (64'h200 << 32) | 64'h001;  walk(sx43(43'h123_4567_8000), 3'd1, 2'd0, "R5");
    t_l1 = (64'h200 << 32) | 64'h101;
    t_l2 = (64'h300 << 32) | 64'h100;  walk(sx43(43'h055_4321_0000), 3'd1, 2'd3, "R5");
    t_l2 = (64'h300 << 32) | 64'h001;  walk(sx43(43'h055_4321_0000), 3'd1, 2'd3, "R5");
    t_l2 = (64'h300 << 32) | 64'h101;
    // R6: leaf not valid
    t_l3 = (64'h4567 << 32) | 64'hFF00; walk(sx43(43'h011_2233_4455), 3'd2, 2'd1, "R6");

    // R7 / R8: sweep mode, access, rights and fault-on bits
    k = 0;
    for (int md = 0; md < 4; md++)
      for (int ai = 0; ai < 4; ai++)
        for (int r = 0; r < 2; r++)
          for (int w = 0; w < 2; w++)
            for (int fo = 0; fo < 8; fo++) begin
              acc = (ai == 0) ? 3'd0 : 3'(1 << (ai - 1));
              rb = r[0] ? 4'(1 << md) : ~4'(1 << md);
              wb = w[0] ? 4'(1 << md) : ~4'(1 << md);
              t_l3 = {32'(32'h1_2345 + k), 16'h0, wb, rb, 4'h0, 3'(fo), 1'b1};
              va = sx43({10'((k * 37) % 1024), 10'((k * 91) % 1024),
                         10'((k * 53) % 1024), 13'((k * 977) % 8192)});
              walk(va, acc, 2'(md), (fo != 0 && r + w > 0) ? "R8" : "R7");
              k++;
            end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule